// File: doc/BRIEF.md
# SPI ADC Register Configuration Sequencer

This block brings up a high-speed ADC through a four-wire SPI link without any processor involvement. One start pulse runs a fixed script: a soft reset of the converter, four setup writes covering the sample format, the output lane mode and a 16-bit test pattern, and then a readback of each setup register with a comparison against the value that was sent. When the script ends, the block reports pass or fail. On a failure it also gives the address of the first register whose readback differed.

A second start input runs a short read-modify-write on the output-mode register. It sets or clears the converter's test-pattern enable bit, leaves every other bit in that register unchanged, and then reads the register back to confirm the change. Link timing comes from a programmable divider, so the same block can drive slow or fast converter interfaces.

Top module: `adc_cfg_seq`

## Requirements
- R1: After reset, chip select is high, SCK is low, and busy, done, pass and fail_addr are all 0.
- R2: The link runs in SPI mode 0:
  - SCK idles low, and MOSI changes only while SCK is low.
  - MISO is sampled on the rising edge of SCK.
  - Bits are sent MSB first.
  - Chip select stays low for exactly 16 SCK cycles per transaction.
  - Between transactions, chip select stays high for at least one SCK period.
- R3: Each high phase and each low phase of SCK lasts clk_div+1 clock cycles, so two rising edges are 2*(clk_div+1) clocks apart.
- R4: A configuration run first performs five writes, in this order: 0x80 to register 0x00, 0x20 to 0x01, 0x11 to 0x02, pattern[15:8] to 0x03, and pattern[7:0] to 0x04.
- R5: Each transaction is two bytes: an address byte followed by a data byte.
  - A write sends {0, addr[6:0]} and then the data.
  - A read sends {1, addr[6:0]} and then 0x00, and takes the register value from the second byte received.
  - After its writes, a configuration run reads registers 0x01, 0x02, 0x03 and 0x04, in that order.
- R6: If every readback matches, the run ends with pass=1 and fail_addr=0. On the first mismatch, the run stops at once with pass=0 and fail_addr set to that register's address.
- R7: A test-mode run works on register 0x02 in three steps:
  - It reads the register as v.
  - It writes v|0x04 when tm_enable=1, or v&0xFB when tm_enable=0.
  - It reads the register back and sets pass according to whether the readback equals the written value. On a mismatch, fail_addr is 0x02.
- R8: Busy rises in the cycle after an accepted start and stays high through the single cycle in which done is 1; it drops in the next cycle. Start pulses that arrive while busy is high are ignored.
- R9: If start_cfg and start_tm are both high in the same idle cycle, the configuration run is the one performed.
- R10: The values of pattern and tm_enable are captured at the start cycle. Changing them later has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cfg | input | 1 | One-cycle pulse that starts the configuration run |
| start_tm | input | 1 | One-cycle pulse that starts the test-mode read-modify-write |
| tm_enable | input | 1 | 1 sets the test-mode bit, 0 clears it |
| pattern | input | 16 | Test pattern written to registers 0x03 and 0x04 |
| clk_div | input | DIV_W | Half-period of SCK minus one, in clock cycles |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Result of the last run, held until the next start |
| fail_addr | output | 7 | Address of the first register that did not match, 0 when the run passed |

## Verification
The assertions assume that clk_div does not change while busy is high, and that the converter drives MISO only in response to SCK edges. The bench changes clk_div only between runs. Its converter model updates MISO on falling SCK edges, away from the sampling edge, and starts are applied only as single-cycle pulses driven on the falling clock edge. Under these conditions, the following properties are expected to hold on every cycle after reset:
- SCK is low whenever chip select is high.
- MOSI holds steady while SCK is high.
- done lasts one cycle and is followed by busy going low.

// File: rtl/adc_cfg_pkg.sv
`timescale 1ns/1ps
package adc_cfg_pkg;

    localparam int SPI_BITS   = 16;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 7;
    localparam int CFG_WRITES = 5;
    localparam int CFG_STEPS  = 2 * CFG_WRITES - 1;
    localparam int TM_STEPS   = 3;
    localparam int STEP_W     = $clog2(CFG_STEPS);

    localparam logic [ADDR_W-1:0] A_RESET = 7'h00;
    localparam logic [ADDR_W-1:0] A_FMT   = 7'h01;
    localparam logic [ADDR_W-1:0] A_LANES = 7'h02;
    localparam logic [ADDR_W-1:0] A_PAT_H = 7'h03;
    localparam logic [ADDR_W-1:0] A_PAT_L = 7'h04;

    localparam logic [BYTE_W-1:0] V_RESET = 8'h80;
    localparam logic [BYTE_W-1:0] V_FMT   = 8'h20;
    localparam logic [BYTE_W-1:0] V_LANES = 8'h11;
    localparam logic [BYTE_W-1:0] TM_MASK = 8'h04;

    typedef enum logic { OP_CFG, OP_TM } op_e;

    typedef enum logic [1:0] { SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_FIN } sq_e;

    typedef struct packed {
        logic              rd;
        logic              chk;
        logic              cap;
        logic              last;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] val;
    } step_t;

    // Value the script writes to a setup register.
    function automatic logic [BYTE_W-1:0] setup_value(logic [ADDR_W-1:0] a,
                                                      logic [15:0] pat);
        case (a)
            A_RESET: return V_RESET;
            A_FMT:   return V_FMT;
            A_LANES: return V_LANES;
            A_PAT_H: return pat[15:8];
            default: return pat[7:0];
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] tm_apply(logic [BYTE_W-1:0] v, logic en);
        return en ? (v | TM_MASK) : (v & ~TM_MASK);
    endfunction

    function automatic logic [SPI_BITS-1:0] spi_word(step_t s);
        return {s.rd, s.addr, (s.rd ? {BYTE_W{1'b0}} : s.val)};
    endfunction

endpackage

// File: rtl/cfg_script.sv
`timescale 1ns/1ps
module cfg_script
    import adc_cfg_pkg::*;
(
    input  op_e               op,
    input  logic [STEP_W-1:0] idx,
    input  logic [15:0]       pattern,
    input  logic              tm_en,
    input  logic [BYTE_W-1:0] held,
    output step_t             step
);
    localparam logic [STEP_W-1:0] LAST_WR = STEP_W'(CFG_WRITES - 1);
    localparam logic [STEP_W-1:0] LAST_CF = STEP_W'(CFG_STEPS - 1);
    localparam logic [STEP_W-1:0] LAST_TM = STEP_W'(TM_STEPS - 1);

    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] tm_val;

    assign rd_addr = ADDR_W'(idx - LAST_WR);
    assign tm_val  = tm_apply(held, tm_en);

    always_comb begin
        step = '0;
        if (op == OP_CFG) begin
            if (idx <= LAST_WR) begin
                step.addr = ADDR_W'(idx);
                step.val  = setup_value(ADDR_W'(idx), pattern);
            end else begin
                step.rd   = 1'b1;
                step.chk  = 1'b1;
                step.addr = rd_addr;
                step.val  = setup_value(rd_addr, pattern);
                step.last = (idx == LAST_CF);
            end
        end else begin
            step.addr = A_LANES;
            step.val  = tm_val;
            case (idx)
                '0: begin
                    step.rd  = 1'b1;
                    step.cap = 1'b1;
                end
                STEP_W'(1): step.rd = 1'b0;
                default: begin
                    step.rd   = 1'b1;
                    step.chk  = 1'b1;
                    step.last = (idx == LAST_TM);
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_xfer16.sv
`timescale 1ns/1ps
module spi_xfer16
    import adc_cfg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [SPI_BITS-1:0] word,
    input  logic [DIV_W-1:0]    div,
    input  logic                miso,
    output logic                sck,
    output logic                cs_n,
    output logic                mosi,
    output logic                xfer_done,
    output logic [BYTE_W-1:0]   rx_byte
);
    localparam int PH_W = $clog2(2 * SPI_BITS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * SPI_BITS - 1);

    typedef enum logic [1:0] { X_IDLE, X_ACT, X_GAP } xst_e;

    xst_e                st;
    logic [DIV_W-1:0]    cnt;
    logic [PH_W-1:0]     ph;
    logic [SPI_BITS-1:0] tx;
    logic [SPI_BITS-1:0] rx_sr;
    logic                gap_half;
    logic                tick;

    assign tick    = (cnt == div);
    assign mosi    = tx[SPI_BITS-1] & ~cs_n;
    assign rx_byte = rx_sr[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= X_IDLE;
            cnt       <= '0;
            ph        <= '0;
            tx        <= '0;
            rx_sr     <= '0;
            sck       <= 1'b0;
            cs_n      <= 1'b1;
            xfer_done <= 1'b0;
            gap_half  <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            case (st)
                X_IDLE: begin
                    if (go) begin
                        st   <= X_ACT;
                        cs_n <= 1'b0;
                        tx   <= word;
                        cnt  <= '0;
                        ph   <= '0;
                    end
                end
                X_ACT: begin
                    if (tick) begin
                        cnt <= '0;
                        ph  <= ph + 1'b1;
                        if (!ph[0]) begin
                            sck   <= 1'b1;
                            rx_sr <= {rx_sr[SPI_BITS-2:0], miso};
                        end else begin
                            sck <= 1'b0;
                            if (ph == PH_LAST) begin
                                cs_n     <= 1'b1;
                                gap_half <= 1'b0;
                                st       <= X_GAP;
                            end else begin
                                tx <= {tx[SPI_BITS-2:0], 1'b0};
                            end
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                X_GAP: begin
                    if (tick) begin
                        cnt      <= '0;
                        gap_half <= 1'b1;
                        if (gap_half) begin
                            st        <= X_IDLE;
                            xfer_done <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= X_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_cfg_seq.sv
`timescale 1ns/1ps
module adc_cfg_seq
    import adc_cfg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_cfg,
    input  logic              start_tm,
    input  logic              tm_enable,
    input  logic [15:0]       pattern,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr
);
    sq_e               st;
    op_e               op;
    logic [STEP_W-1:0] idx;
    logic [15:0]       pat_q;
    logic              en_q;
    logic [BYTE_W-1:0] held;
    step_t             step;
    logic              go;
    logic              xdone;
    logic [BYTE_W-1:0] rx;

    assign go   = (st == SQ_ISSUE);
    assign busy = (st != SQ_IDLE);

    cfg_script u_script (
        .op      (op),
        .idx     (idx),
        .pattern (pat_q),
        .tm_en   (en_q),
        .held    (held),
        .step    (step)
    );

    spi_xfer16 #(.DIV_W(DIV_W)) u_spi (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .word      (spi_word(step)),
        .div       (clk_div),
        .miso      (spi_miso),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .xfer_done (xdone),
        .rx_byte   (rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            op        <= OP_CFG;
            idx       <= '0;
            pat_q     <= '0;
            en_q      <= 1'b0;
            held      <= '0;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail_addr <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start_cfg || start_tm) begin
                        op        <= start_cfg ? OP_CFG : OP_TM;
                        idx       <= '0;
                        pat_q     <= pattern;
                        en_q      <= tm_enable;
                        pass      <= 1'b0;
                        fail_addr <= '0;
                        st        <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: st <= SQ_WAIT;
                SQ_WAIT: begin
                    if (xdone) begin
                        if (step.cap) held <= rx;
                        if (step.chk && (rx != step.val)) begin
                            fail_addr <= step.addr;
                            pass      <= 1'b0;
                            done      <= 1'b1;
                            st        <= SQ_FIN;
                        end else if (step.last) begin
                            pass <= 1'b1;
                            done <= 1'b1;
                            st   <= SQ_FIN;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= SQ_ISSUE;
                        end
                    end
                end
                SQ_FIN:  st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_cfg_seq_chk.sv
`timescale 1ns/1ps
module adc_cfg_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       pass,
    input logic [6:0] fail_addr,
    input logic       sck,
    input logic       cs_n,
    input logic       mosi
);
    a_r2_sck_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    a_r2_mosi_steady_while_high: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

    a_r1_cs_high_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

    a_r8_done_inside_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r8_done_single_then_idle: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    a_r6_pass_clears_addr: assert property (@(posedge clk) disable iff (rst)
        pass |-> (fail_addr == 7'd0));
endmodule

bind adc_cfg_seq adc_cfg_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fail_addr (fail_addr),
    .sck       (spi_sck),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi)
);

// File: tb/sim_adc_cfg_seq.sv
`timescale 1ns/1ps
module sim_adc_cfg_seq;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_cfg = 1'b0;
    logic          start_tm = 1'b0;
    logic          tm_enable = 1'b0;
    logic [15:0]   pattern = 16'h811F;
    logic [DW-1:0] clk_div = 8'd3;
    logic          sck, cs_n, mosi;
    logic          miso = 1'b0;
    logic          busy, done, pass;
    logic [6:0]    fail_addr;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    adc_cfg_seq #(.DIV_W(DW)) u0 (
        .clk(clk), .rst(rst), .start_cfg(start_cfg), .start_tm(start_tm),
        .tm_enable(tm_enable), .pattern(pattern), .clk_div(clk_div),
        .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
        .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr)
    );

    // Converter model: register file with optional stuck-high bits on readback.
    logic [7:0]  sreg [0:7];
    logic [7:0]  fmask [0:7];
    logic [7:0]  log_a [0:31];
    logic [7:0]  log_d [0:31];
    int          ntx = 0;
    int          bitn = 0;
    logic [15:0] shin = '0;
    logic [7:0]  shout = '0;
    realtime     t_r1 = 0, t_r2 = 0, t_rise = 0, gap_min = 1.0e9;
    bit          seen_rise = 0;

    always @(negedge cs_n) begin
        bitn = 0;
        if (seen_rise && ($realtime - t_rise) < gap_min) gap_min = $realtime - t_rise;
    end
    always @(posedge cs_n) begin
        t_rise = $realtime;
        seen_rise = 1;
    end

    always @(posedge sck) begin
        shin = {shin[14:0], mosi};
        bitn = bitn + 1;
        if (ntx == 0 && bitn == 1) t_r1 = $realtime;
        if (ntx == 0 && bitn == 2) t_r2 = $realtime;
        if (bitn == 8 && shin[7]) shout = sreg[shin[2:0]] | fmask[shin[2:0]];
        if (bitn == 16) begin
            if (ntx < 32) begin
                log_a[ntx] = shin[15:8];
                log_d[ntx] = shin[7:0];
            end
            ntx = ntx + 1;
            if (!shin[15]) begin
                if (shin[10:8] == 3'd0 && shin[7]) begin
                    for (int i = 0; i < 8; i++) sreg[i] = 8'h00;
                end else begin
                    sreg[shin[10:8]] = shin[7:0];
                end
            end
        end
    end

    always @(negedge sck) begin
        if (bitn >= 8 && bitn < 16) miso <= shout[15 - bitn];
        else miso <= 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        ntx = 0;
        seen_rise = 0;
        gap_min = 1.0e9;
        for (int i = 0; i < 8; i++) fmask[i] = 8'h00;
    endtask

    logic got_pass;
    logic [6:0] got_fa;

    task automatic pulse(input bit cfg, input bit tm);
        @(negedge clk);
        start_cfg = cfg;
        start_tm = tm;
        @(negedge clk);
        start_cfg = 1'b0;
        start_tm = 1'b0;
    endtask

    task automatic wait_done();
        bit seen = 0;
        for (int i = 0; i < 30000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk(seen, "R8 done seen", int'(seen), 1);
        got_pass = pass;
        got_fa = fail_addr;
        @(negedge clk);
        chk(!done && !busy, "R8 done one cycle then idle", {done, busy}, 0);
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1 && sck == 1'b0, "R1 link idle", {cs_n, sck}, 2);
        chk({busy, done, pass, fail_addr} == '0, "R1 status clear",
            {busy, done, pass, fail_addr}, 0);
    endtask

    task automatic t_cfg(input logic [15:0] pat, input logic [7:0] dv);
        logic [7:0] ev [0:4];
        ev[0] = 8'h80; ev[1] = 8'h20; ev[2] = 8'h11; ev[3] = pat[15:8]; ev[4] = pat[7:0];
        clk_div = dv;
        pattern = pat;
        clear_log();
        pulse(1, 0);
        chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        wait_done();
        chk(got_pass == 1'b1 && got_fa == 0, "R6 pass", {got_pass, got_fa}, 8'h80);
        chk(ntx == 9, "R4 R5 transaction count", ntx, 9);
        for (int k = 0; k < 5; k++)
            chk(log_a[k] == 8'(k) && log_d[k] == ev[k], "R4 write order",
                {log_a[k], log_d[k]}, {8'(k), ev[k]});
        for (int k = 5; k < 9; k++)
            chk(log_a[k] == (8'h80 | 8'(k - 4)) && log_d[k] == 8'h00, "R5 read frame",
                {log_a[k], log_d[k]}, {(8'h80 | 8'(k - 4)), 8'h00});
        chk(sreg[3] == pat[15:8] && sreg[4] == pat[7:0], "R4 pattern stored",
            {sreg[3], sreg[4]}, pat);
        chk((t_r2 - t_r1) == 20.0 * (dv + 1), "R3 sck period",
            int'(t_r2 - t_r1), 20 * (dv + 1));
        chk(gap_min >= 20.0 * (dv + 1), "R2 cs gap", int'(gap_min), 20 * (dv + 1));
    endtask

    task automatic t_cfg_fault();
        clk_div = 8'd1;
        pattern = 16'h40AA;
        clear_log();
        fmask[3] = 8'h01;
        pulse(1, 0);
        wait_done();
        chk(got_pass == 1'b0 && got_fa == 7'd3, "R6 first mismatch", {got_pass, got_fa}, 3);
        chk(ntx == 8, "R6 stops after mismatch", ntx, 8);
    endtask

    task automatic t_tm(input bit en, input logic [7:0] init, input logic [7:0] mask,
                        input bit exp_pass);
        logic [7:0] nv;
        nv = en ? (init | 8'h04) : (init & 8'hFB);
        clear_log();
        sreg[2] = init;
        fmask[2] = mask;
        tm_enable = en;
        pulse(0, 1);
        tm_enable = ~en;
        wait_done();
        chk(ntx == 3, "R7 three transactions", ntx, 3);
        chk(log_a[0] == 8'h82 && log_a[1] == 8'h02 && log_a[2] == 8'h82, "R7 addresses",
            {log_a[0], log_a[1], log_a[2]}, 24'h820282);
        chk(log_d[1] == ((init | mask) & 8'hFB | (en ? 8'h04 : 8'h00)), "R7 R10 modified value",
            log_d[1], (init | mask) & 8'hFB | (en ? 8'h04 : 8'h00));
        chk(got_pass == exp_pass && got_fa == (exp_pass ? 7'd0 : 7'd2), "R7 verify result",
            {got_pass, got_fa}, exp_pass ? 8'h80 : 8'h02);
        if (mask == 0) chk(sreg[2] == nv, "R7 register updated", sreg[2], nv);
    endtask

    task automatic t_ignore_busy();
        clk_div = 8'd0;
        pattern = 16'h1357;
        clear_log();
        pulse(1, 0);
        repeat (20) @(negedge clk);
        pulse(0, 1);
        pulse(1, 0);
        wait_done();
        repeat (60) @(negedge clk);
        chk(ntx == 9, "R8 start while busy ignored", ntx, 9);
        chk(!busy, "R8 stays idle", int'(busy), 0);
    endtask

    task automatic t_priority();
        clk_div = 8'd0;
        pattern = 16'hC3A5;
        clear_log();
        pulse(1, 1);
        wait_done();
        chk(ntx == 9 && log_a[0] == 8'h00, "R9 config wins", ntx, 9);
    endtask

    task automatic t_latch();
        clk_div = 8'd2;
        pattern = 16'h5A3C;
        clear_log();
        @(negedge clk);
        start_cfg = 1'b1;
        @(negedge clk);
        start_cfg = 1'b0;
        pattern = 16'hFFFF;
        wait_done();
        chk({sreg[3], sreg[4]} == 16'h5A3C && got_pass, "R10 pattern captured at start",
            {sreg[3], sreg[4]}, 16'h5A3C);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            sreg[i] = 8'h00;
            fmask[i] = 8'h00;
        end
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cfg(16'h811F, 8'd3);
        t_cfg(16'h1234, 8'd0);
        t_tm(1'b1, 8'h11, 8'h00, 1'b1);
        t_tm(1'b0, 8'h15, 8'h00, 1'b1);
        t_tm(1'b0, 8'hFF, 8'h00, 1'b1);
        t_tm(1'b0, 8'h11, 8'h04, 1'b0);
        t_cfg_fault();
        t_ignore_busy();
        t_priority();
        t_latch();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule